// File: doc/BRIEF.md
# CAN transmit mailbox status tracker

This block keeps the transmit-side bookkeeping for three CAN transmit mailboxes and presents it as one 32-bit status word. Software asks for transmissions and aborts, and clears result flags by strobing ones. The protocol engine says which mailbox it is currently sending and reports the outcome of each attempt. From these inputs the block keeps a pending state, an abort request and four result flags for each mailbox.

On top of the per-mailbox state, the block compares a priority key for each pending mailbox. A lower key wins arbitration. The block flags the pending mailbox that would go last. It also produces a 2-bit mailbox code that has two meanings. While any mailbox is free, the code names a free one that software can fill next. When all three are pending, it names the mailbox that would go last, so that software knows which one to abort.

The status word is driven combinationally from the registered mailbox state and the live priority keys. Framing, bit timing and message storage belong to other blocks.

Top module: `can_txmb_status`

## Requirements
- R1: After reset the status word reads 0x1C000000: all three empty flags (bits 26+i for mailbox i) are 1 and every other bit is 0.
- R2: A request pulse on sw_req[i] for an empty mailbox makes it pending, and its empty flag reads 0 one cycle later. A request for a mailbox that is already pending has no effect on the status word.
- R3: A completion event (eng_done with eng_done_mb = i) for a pending mailbox empties it. In the same edge it sets request-completed (bit 8i) and overwrites transmit-OK (bit 8i+1), arbitration-lost (bit 8i+2) and transmit-error (bit 8i+3) with eng_ok, eng_alst and eng_terr. A completion event for a mailbox that is not pending has no effect.
- R4: A 1 on sw_clr[4i+k] clears flag k of mailbox i, with k = 0 for request-completed, 1 for transmit-OK, 2 for arbitration-lost and 3 for transmit-error. Flags whose clear bit is 0 keep their value. When a completion event sets a flag in the same cycle as that flag is cleared, the event wins.
- R5: An abort (sw_abort[i]) of a pending mailbox whose eng_tx[i] is 0 empties it at the next edge. It also sets request-completed, clears transmit-OK, arbitration-lost and transmit-error, and leaves the abort bit (bit 8i+7) at 0.
- R6: An abort of a pending mailbox whose eng_tx[i] is 1 sets the abort bit, and the mailbox stays pending. When the completion event arrives, the mailbox empties, the abort bit clears and the result flags follow R3. The abort bit is never 1 while the mailbox is empty.
- R7: An abort of an empty mailbox has no effect.
- R8: When two or more mailboxes are pending, exactly one lowest-priority flag (bit 29+i) is set. It marks the pending mailbox with the highest key, and on equal keys the higher mailbox number. With one or no mailbox pending, bits 31..29 are all 0.
- R9: Bits 25..24 hold the lowest-numbered free mailbox while any is free. When all three are pending, they hold the number of the lowest-priority mailbox.
- R10: Bits 22..20, 14..12 and 6..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req | input | 3 | Transmit request strobe, one bit per mailbox |
| sw_abort | input | 3 | Abort request strobe, one bit per mailbox |
| sw_clr | input | 12 | Write-one-to-clear strobes, four per mailbox (k = 0 complete, 1 OK, 2 arbitration lost, 3 error) |
| prio_key | input | 3*KEY_W | Priority key of mailbox i at [i*KEY_W +: KEY_W]; the lower value wins |
| eng_tx | input | 3 | Mailbox currently being transmitted by the engine |
| eng_done | input | 1 | Completion event strobe |
| eng_done_mb | input | 2 | Mailbox number of the completion event (3 is ignored) |
| eng_ok | input | 1 | Attempt succeeded |
| eng_alst | input | 1 | Attempt lost arbitration |
| eng_terr | input | 1 | Attempt failed with an error |
| status_word | output | 32 | Status word |

## Verification
The checker watches several properties on every cycle. It confirms that the reserved bits stay 0 and that the lowest-priority flags are one-hot or clear, and clear when fewer than two mailboxes are pending. It checks that the code points at the flagged mailbox when all are full, and that an abort bit never shows on an empty mailbox. It also checks that requests, completions and aborts of empty mailboxes have their next-cycle effect on the empty, completed and abort bits. Only the directed scenarios can show the exact values of the result flags. The same holds for the outcome of an event colliding with a clear, and for the tie-break between equal keys. The scenarios also cover the two abort paths, with a mailbox out of transmission and in transmission, and confirm that a repeated request or a stray completion leaves the whole word unchanged.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int NUM_MB   = 3;
    localparam int CODE_W   = 2;
    localparam int FLAGS_MB = 4;

    // Bit positions inside the status word
    localparam int LOW_LSB  = 29;
    localparam int TME_LSB  = 26;
    localparam int CODE_LSB = 24;
    localparam int MB_STEP  = 8;
    localparam int B_RQCP   = 0;
    localparam int B_TXOK   = 1;
    localparam int B_ALST   = 2;
    localparam int B_TERR   = 3;
    localparam int B_ABRQ   = 7;

    typedef struct packed {
        logic pend;
        logic abrq;
        logic rqcp;
        logic txok;
        logic alst;
        logic terr;
    } mb_state_t;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
    import can_txmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      abort_wr,
    input  logic [3:0] clr,
    input  logic      in_tx,
    input  logic      done,
    input  logic      done_ok,
    input  logic      done_alst,
    input  logic      done_terr,
    output mb_state_t st
);

    mb_state_t st_d, st_q;
    logic      abort_any;

    always_comb begin
        st_d      = st_q;
        abort_any = st_q.abrq || abort_wr;

        if (clr[B_RQCP]) st_d.rqcp = 1'b0;
        if (clr[B_TXOK]) st_d.txok = 1'b0;
        if (clr[B_ALST]) st_d.alst = 1'b0;
        if (clr[B_TERR]) st_d.terr = 1'b0;

        if (st_q.pend) begin
            if (done) begin
                st_d.pend = 1'b0;
                st_d.abrq = 1'b0;
                st_d.rqcp = 1'b1;
                st_d.txok = done_ok;
                st_d.alst = done_alst;
                st_d.terr = done_terr;
            end else if (abort_any && !in_tx) begin
                st_d.pend = 1'b0;
                st_d.abrq = 1'b0;
                st_d.rqcp = 1'b1;
                st_d.txok = 1'b0;
                st_d.alst = 1'b0;
                st_d.terr = 1'b0;
            end else if (abort_wr) begin
                st_d.abrq = 1'b1;
            end
        end else if (req) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb
    import can_txmb_pkg::*;
#(
    parameter int KEY_W = 11
) (
    input  logic [NUM_MB-1:0]       pend,
    input  logic [NUM_MB*KEY_W-1:0] keys,
    output logic [NUM_MB-1:0]       low,
    output logic [CODE_W-1:0]       code
);

    localparam int CNT_W = $clog2(NUM_MB + 1);

    logic [KEY_W-1:0]  key_arr [NUM_MB];
    logic [CODE_W-1:0] worst_d;
    logic [KEY_W-1:0]  worst_key_d;
    logic              found_d;
    logic [CNT_W-1:0]  cnt_d;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_key
        assign key_arr[g] = keys[g*KEY_W +: KEY_W];
    end

    always_comb begin
        worst_d     = '0;
        worst_key_d = '0;
        found_d     = 1'b0;
        cnt_d       = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i]) begin
                cnt_d = cnt_d + 1'b1;
                if (!found_d || key_arr[i] >= worst_key_d) begin
                    found_d     = 1'b1;
                    worst_d     = CODE_W'(i);
                    worst_key_d = key_arr[i];
                end
            end
        end

        low = '0;
        if (cnt_d >= CNT_W'(2)) begin
            low[worst_d] = 1'b1;
        end

        code = worst_d;
        if (!(&pend)) begin
            for (int i = NUM_MB - 1; i >= 0; i--) begin
                if (!pend[i]) code = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_txmb_status.sv
module can_txmb_status
    import can_txmb_pkg::*;
#(
    parameter int KEY_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_MB-1:0]       sw_req,
    input  logic [NUM_MB-1:0]       sw_abort,
    input  logic [NUM_MB*4-1:0]     sw_clr,
    input  logic [NUM_MB*KEY_W-1:0] prio_key,
    input  logic [NUM_MB-1:0]       eng_tx,
    input  logic                    eng_done,
    input  logic [CODE_W-1:0]       eng_done_mb,
    input  logic                    eng_ok,
    input  logic                    eng_alst,
    input  logic                    eng_terr,
    output logic [31:0]             status_word
);

    mb_state_t         mb_st [NUM_MB];
    logic [NUM_MB-1:0] pend_vec;
    logic [NUM_MB-1:0] low_vec;
    logic [CODE_W-1:0] code_val;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic done_here;
        assign done_here = eng_done && (eng_done_mb == CODE_W'(g));

        can_txmb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (sw_req[g]),
            .abort_wr  (sw_abort[g]),
            .clr       (sw_clr[g*FLAGS_MB +: FLAGS_MB]),
            .in_tx     (eng_tx[g]),
            .done      (done_here),
            .done_ok   (eng_ok),
            .done_alst (eng_alst),
            .done_terr (eng_terr),
            .st        (mb_st[g])
        );

        assign pend_vec[g] = mb_st[g].pend;
    end

    can_txmb_arb #(.KEY_W(KEY_W)) u_arb (
        .pend (pend_vec),
        .keys (prio_key),
        .low  (low_vec),
        .code (code_val)
    );

    always_comb begin
        status_word = '0;
        status_word[CODE_LSB +: CODE_W] = code_val;
        for (int i = 0; i < NUM_MB; i++) begin
            status_word[LOW_LSB + i]          = low_vec[i];
            status_word[TME_LSB + i]          = !mb_st[i].pend;
            status_word[MB_STEP*i + B_ABRQ]   = mb_st[i].abrq;
            status_word[MB_STEP*i + B_TERR]   = mb_st[i].terr;
            status_word[MB_STEP*i + B_ALST]   = mb_st[i].alst;
            status_word[MB_STEP*i + B_TXOK]   = mb_st[i].txok;
            status_word[MB_STEP*i + B_RQCP]   = mb_st[i].rqcp;
        end
    end

endmodule

// File: rtl/can_txmb_status_chk.sv
module can_txmb_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  sw_req,
    input logic [2:0]  sw_abort,
    input logic        eng_done,
    input logic [1:0]  eng_done_mb,
    input logic [31:0] status_word
);

    logic [2:0] tme;
    logic [2:0] low;
    logic [1:0] code;

    assign tme  = status_word[28:26];
    assign low  = status_word[31:29];
    assign code = status_word[25:24];

    // R10: reserved bits stay zero
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[22:20] == 3'b0) && (status_word[14:12] == 3'b0) && (status_word[6:4] == 3'b0));

    // R8: at most one lowest-priority flag
    p_low_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(low));

    // R8: no flag with fewer than two pending
    p_low_few_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~tme) < 2) |-> (low == 3'b000));

    // R9: code names the flagged mailbox when all are full
    p_code_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tme == 3'b000) |-> (low == (3'b001 << code)));

    for (genvar g = 0; g < 3; g++) begin : g_chk
        // R2: request on an empty mailbox makes it pending
        p_req_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_req[g] && tme[g]) |=> !tme[g]);

        // R3: completion on a pending mailbox empties it and sets complete
        p_done_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (eng_done && (eng_done_mb == 2'(g)) && !tme[g]) |=> (tme[g] && status_word[8*g]));

        // R6: abort bit never shows on an empty mailbox
        p_abrq_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[8*g + 7] |-> !tme[g]);

        // R7: abort of an empty mailbox leaves the abort bit clear
        p_abort_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_abort[g] && tme[g]) |=> !status_word[8*g + 7]);
    end

endmodule

bind can_txmb_status can_txmb_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (sw_req),
    .sw_abort    (sw_abort),
    .eng_done    (eng_done),
    .eng_done_mb (eng_done_mb),
    .status_word (status_word)
);

// File: tb/sim_can_txmb_status.sv
module sim_can_txmb_status;

    localparam int KEY_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        sw_req = '0;
    logic [2:0]        sw_abort = '0;
    logic [11:0]       sw_clr = '0;
    logic [3*KEY_W-1:0] prio_key = '0;
    logic [2:0]        eng_tx = '0;
    logic              eng_done = 1'b0;
    logic [1:0]        eng_done_mb = '0;
    logic              eng_ok = 1'b0;
    logic              eng_alst = 1'b0;
    logic              eng_terr = 1'b0;
    logic [31:0]       status_word;

    int tests  = 0;
    int failed = 0;

    always #5 clk = ~clk;

    can_txmb_status #(.KEY_W(KEY_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_req      (sw_req),
        .sw_abort    (sw_abort),
        .sw_clr      (sw_clr),
        .prio_key    (prio_key),
        .eng_tx      (eng_tx),
        .eng_done    (eng_done),
        .eng_done_mb (eng_done_mb),
        .eng_ok      (eng_ok),
        .eng_alst    (eng_alst),
        .eng_terr    (eng_terr),
        .status_word (status_word)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        sw_req   = '0;
        sw_abort = '0;
        sw_clr   = '0;
        eng_done = 1'b0;
        eng_ok   = 1'b0;
        eng_alst = 1'b0;
        eng_terr = 1'b0;
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] exp);
        tests++;
        if (status_word !== exp) begin
            failed++;
            $display("FAIL %s: status=%h expected=%h", req, status_word, exp);
        end
    endtask

    task automatic set_keys(input int k0, input int k1, input int k2);
        prio_key = {KEY_W'(k2), KEY_W'(k1), KEY_W'(k0)};
        #1;
    endtask

    task automatic done_ev(input logic [1:0] mb, input logic ok, input logic al, input logic er);
        eng_done    = 1'b1;
        eng_done_mb = mb;
        eng_ok      = ok;
        eng_alst    = al;
        eng_terr    = er;
    endtask

    task automatic t_reset();
        chk("R1 reset value", 32'h1C00_0000);
    endtask

    task automatic t_request();
        set_keys(5, 9, 9);
        sw_req = 3'b001; tick();
        chk("R2 request mb0, R9 lowest free", 32'h1900_0000);
        sw_req = 3'b001; tick();
        chk("R2 repeated request ignored", 32'h1900_0000);
        sw_req = 3'b110; tick();
        chk("R8 R9 all pending, tie to higher index", 32'h8200_0000);
        set_keys(20, 9, 9);
        chk("R8 R9 highest key is lowest priority", 32'h2000_0000);
    endtask

    task automatic t_done();
        done_ev(2'd2, 1'b1, 1'b0, 1'b0); tick();
        chk("R3 completion ok mb2, R8 two pending", 32'h3203_0000);
        done_ev(2'd1, 1'b0, 1'b1, 1'b0); tick();
        chk("R3 completion alst mb1, R8 one pending", 32'h1903_0500);
        done_ev(2'd1, 1'b0, 1'b0, 1'b1); tick();
        chk("R3 completion on empty mailbox ignored", 32'h1903_0500);
    endtask

    task automatic t_clear();
        sw_clr = 12'h200; tick();
        chk("R4 clear txok of mb2 only", 32'h1901_0500);
        sw_clr = 12'h000; tick();
        chk("R4 zero clear has no effect", 32'h1901_0500);
        done_ev(2'd0, 1'b1, 1'b0, 1'b0);
        sw_clr = 12'h001; tick();
        chk("R4 event beats clear of rqcp", 32'h1C01_0503);
        sw_clr = 12'hFFF; tick();
        chk("R4 clear all flags", 32'h1C00_0000);
    endtask

    task automatic t_abort_idle();
        sw_req = 3'b010; tick();
        chk("R2 request mb1", 32'h1400_0000);
        sw_abort = 3'b010; tick();
        chk("R5 abort idle mailbox empties at once", 32'h1C00_0100);
        sw_clr = 12'h010; tick();
        chk("R4 clear rqcp mb1", 32'h1C00_0000);
    endtask

    task automatic t_abort_tx();
        eng_tx = 3'b100;
        sw_req = 3'b100; tick();
        chk("R2 request mb2", 32'h0C00_0000);
        sw_abort = 3'b100; tick();
        chk("R6 abort in transmission holds abort bit", 32'h0C80_0000);
        tick();
        chk("R6 still pending while in transmission", 32'h0C80_0000);
        done_ev(2'd2, 1'b0, 1'b0, 1'b1); tick();
        eng_tx = 3'b000;
        chk("R6 completion clears abort, R3 error flag", 32'h1C09_0000);
        sw_clr = 12'h900; tick();
        chk("R4 clear mb2 flags", 32'h1C00_0000);
    endtask

    task automatic t_abort_empty();
        sw_abort = 3'b111; tick();
        chk("R7 abort of empty mailboxes ignored", 32'h1C00_0000);
        tick();
        chk("R10 R7 word still at rest", 32'h1C00_0000);
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        #1;
        tick();
        t_reset();
        t_request();
        t_done();
        t_clear();
        t_abort_idle();
        t_abort_tx();
        t_abort_empty();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule